// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a watchdog timer that sits behind a simple word-wide register port. Software programs a timeout, measured in ticks, into a count register and then sets a run bit. From then on it must write a reload strobe before that many ticks have passed. Each reload copies the programmed timeout into the running counter, so the countdown starts again from the full value.

Ticks come from an external enable pulse, typically one per second. If the counter runs out while the timer is running, the block does three things. It latches a fired flag, it emits a single-clock request on one of two action outputs (reset or shutdown, chosen by a control bit), and it then stays quiet until the next reload. A global disable input stops any firing and shows up as a read-only status bit.

There are two registers. The control word sits at byte offset 0x0 and the count register at byte offset 0x4. Only address bit 2 selects between them, so the block suits an 8-byte-aligned base.

Top module: `tick_watchdog`

## Requirements
- R1: Address bit 2 selects the register: 0 reads or writes the control word, 1 reads or writes the count register. Reads are combinational from `addr`.
- R2: Control bit 0 is the run bit. While it is 0 the counter holds its value and no action request is ever produced.
- R3: Control bit 1 is the fired flag. It is set when the countdown expires. Writing a 1 to it clears it, and writing a 0 leaves it unchanged. If expiry and a clear land in the same cycle, the set wins.
- R4: Control bit 2 selects the action. When it is 1, expiry pulses `shut_req`. When it is 0, expiry pulses `rst_req`. The two requests are never active together.
- R5: Control bit 3 reads the `hw_off` input and ignores writes. While `hw_off` is 1 the counter is frozen and no action request is produced.
- R6: Control bits 6:4 and 31:8 read as zero. Bit 7 is the reload strobe and also reads as zero.
- R7: Writing the control word with bit 7 set copies the count register into the running counter and arms the timer. With a programmed value N, expiry occurs on tick number max(N,1) after the reload.
- R8: The count register keeps bits 15:0 of a write. Bits 31:16 are ignored on write and read as zero.
- R9: The counter changes only in cycles where `tick_en` is 1. With no ticks, the timer never expires.
- R10: An action request lasts exactly one clock, in the cycle after the expiring tick. After that the timer stays disarmed and does not fire again until the next reload.
- R11: A reload written in the same cycle as an expiring tick takes priority. No fire occurs and the counter restarts from the count register.
- R12: After reset, the run bit, fired flag, action select, count register and running counter are all 0, the timer is disarmed, and both action outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base pulse; one clock wide per tick |
| hw_off | input | 1 | Global disable; blocks firing and reads back in control bit 3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte address; bit 2 selects the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register selected by `addr` |
| rst_req | output | 1 | One-clock system reset request |
| shut_req | output | 1 | One-clock shutdown request |

## Verification
The embedded properties enforce the following on every cycle:
- no request while the run bit is clear or `hw_off` is high;
- never both requests at once;
- the request kind matches the select bit held before the pulse;
- the fired flag is set whenever a request appears;
- every request lasts a single clock;
- a reload cycle is never followed by a request;
- reserved and upper bits always read as zero.

Only the bench's scenarios can show that expiry lands on exactly the programmed tick count. The same holds for the zero-count case, for ticks being required, for the write-one-to-clear semantics, and for the reload-at-expiry race. The bench covers these with a behavioural model compared on every clock.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              hw_off,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              shut_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, fired_q, act_q, armed_q;
  logic [CNT_W-1:0] cfg_q, cur_q;

  wire sel_cnt = addr[2];
  wire wr_ctrl = wr_en && !sel_cnt;
  wire wr_cnt  = wr_en && sel_cnt;
  wire reload  = wr_ctrl && wdata[7];
  wire step    = tick_en && run_q && armed_q && !hw_off && !reload;
  wire expire  = step && (cur_q <= ONE);

  wire unused_ok = ^{addr[1:0], wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (reload) begin
      cur_q   <= cfg_q;
      armed_q <= 1'b1;
    end else if (expire) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (step) begin
      cur_q   <= cur_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      act_q    <= 1'b0;
      fired_q  <= 1'b0;
      cfg_q    <= '0;
      rst_req  <= 1'b0;
      shut_req <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata[0];
        act_q <= wdata[2];
      end
      if (expire)
        fired_q <= 1'b1;
      else if (wr_ctrl && wdata[1])
        fired_q <= 1'b0;
      if (wr_cnt)
        cfg_q <= wdata[CNT_W-1:0];
      rst_req  <= expire && !act_q;
      shut_req <= expire && act_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_cnt)
      rdata[CNT_W-1:0] = cfg_q;
    else
      rdata[3:0] = {hw_off, act_q, fired_q, run_q};
  end

  a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !(rst_req || shut_req));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !shut_req);
  a_r4_reset_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(!act_q));
  a_r4_shut_kind: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |-> $past(act_q));
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hw_off |=> !(rst_req || shut_req));
  a_r3_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || shut_req) |-> fired_q);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || shut_req) |=> !(rst_req || shut_req));
  a_r11_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !(rst_req || shut_req));
  a_r6_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cnt |-> rdata[DATA_W-1:4] == '0);
  a_r8_cnt_upper: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt |-> rdata[DATA_W-1:CNT_W] == '0);
endmodule

// File: tb/tb_tick_watchdog.sv
module tb_tick_watchdog;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, hw_off = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, shut_req;

  tick_watchdog dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hw_off(hw_off),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rst_req(rst_req), .shut_req(shut_req));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  int n_rst = 0, n_shut = 0;
  int m_run, m_fired, m_act, m_cfg, m_cur, m_armed, m_rst, m_shut;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_fired = 0; m_act = 0; m_cfg = 0; m_cur = 0; m_armed = 0; m_rst = 0; m_shut = 0;
    end else begin
      int old_act, fire;
      old_act = m_act; fire = 0;
      if (wr_en && !addr[2] && wdata[7]) begin
        m_cur = m_cfg; m_armed = 1;
      end else if (tick_en && m_run != 0 && m_armed != 0 && !hw_off) begin
        if (m_cur <= 1) begin m_cur = 0; m_armed = 0; fire = 1; end
        else m_cur = m_cur - 1;
      end
      if (wr_en && !addr[2]) begin
        m_run = wdata[0]; m_act = wdata[2];
        if (wdata[1]) m_fired = 0;
      end
      if (wr_en && addr[2]) m_cfg = wdata & 32'hFFFF;
      if (fire) m_fired = 1;
      m_rst  = fire && old_act == 0;
      m_shut = fire && old_act != 0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      longint exp;
      exp = addr[2] ? longint'(m_cfg)
                    : longint'((int'(hw_off) << 3) | (m_act << 2) | (m_fired << 1) | m_run);
      chk(rdata == 32'(exp), addr[2] ? "R8 count readback" : "R1 R6 control readback", rdata, exp);
      chk(rst_req == m_rst[0], "R10 rst_req pulse", rst_req, m_rst);
      chk(shut_req == m_shut[0], "R4 shut_req pulse", shut_req, m_shut);
      if (rst_req) n_rst++;
      if (shut_req) n_shut++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 3'd0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int r0, s0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 32'h0, "R12 reset control", rdata, 0);
    chk(!rst_req && !shut_req, "R12 reset outputs", {rst_req, shut_req}, 0);

    wr(3'd4, 32'hABCD_0003);
    @(negedge clk); addr = 3'd4; #1;
    chk(rdata == 32'h0000_0003, "R8 upper bits dropped", rdata, 32'h3);
    addr = 3'd0;

    r0 = n_rst;
    wr(3'd0, 32'h81);
    idle(20);
    chk(n_rst == r0, "R9 no tick no fire", n_rst - r0, 0);
    ticks(2);
    chk(n_rst == r0, "R7 not before third tick", n_rst - r0, 0);
    ticks(1); idle(1);
    chk(n_rst == r0 + 1, "R7 fires on tick three", n_rst - r0, 1);
    ticks(5); idle(1);
    chk(n_rst == r0 + 1, "R10 hold until reload", n_rst - r0, 1);

    wr(3'd0, 32'h01); #1;
    chk(rdata[1] == 1'b1, "R3 write zero keeps flag", rdata[1], 1);
    wr(3'd0, 32'h03); #1;
    chk(rdata[1] == 1'b0, "R3 write one clears", rdata[1], 0);

    s0 = n_shut;
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h85);
    ticks(1); idle(1);
    chk(n_shut == s0 + 1, "R4 shutdown on zero count", n_shut - s0, 1);
    chk(n_rst == r0 + 1, "R4 no reset request", n_rst - r0, 1);

    wr(3'd4, 32'h4);
    wr(3'd0, 32'h81);
    ticks(2);
    wr(3'd0, 32'h00);
    ticks(6); idle(1);
    chk(n_rst == r0 + 1, "R2 run clear no fire", n_rst - r0, 1);

    hw_off = 1'b1;
    wr(3'd0, 32'h81); #1;
    chk(rdata[3] == 1'b1, "R5 disable status", rdata[3], 1);
    ticks(8); idle(1);
    chk(n_rst == r0 + 1, "R5 disabled never fires", n_rst - r0, 1);
    hw_off = 1'b0;

    wr(3'd4, 32'h2);
    wr(3'd0, 32'h81);
    ticks(1);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 32'h81;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0; wdata = '0;
    idle(1);
    chk(n_rst == r0 + 1, "R11 reload beats expiry", n_rst - r0, 1);
    ticks(2); idle(1);
    chk(n_rst == r0 + 2, "R11 restarted count", n_rst - r0, 2);

    wr(3'd0, 32'hFF); #1;
    chk(rdata[31:4] == '0, "R6 reserved zero", rdata, rdata & 32'hF);
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule